// File: doc/BRIEF.md
# Vector Address Generation Unit

This block decodes one vector address-compute instruction and evaluates it across a vector of parameterised width (256 bits by default). Each cycle it may accept a 32-bit instruction word together with two source vectors that the surrounding pipeline has already read: a base vector and an offset vector. For every lane it forms the base plus the offset shifted left by 0 to 3 bits. The instruction selects the lane layout and chooses how the offset is widened.

One cycle after an accepted word, the result vector and the destination register index appear on registered outputs, together with a valid flag. A word that does not match the fixed opcode bits raises an illegal flag for one cycle and produces no result. The source-register fields (bits 20:16 and 9:5) belong to the register-read stage and play no part here. Every lane is written, because the operation has no predicate.

Top module: `vec_addr_gen`

## Requirements
- R1: A word with bits 31:24 = 8'h04, bit 21 = 1 and bits 15:12 = 4'hA, presented with valid_i high, is legal. On the next clock valid_o is high, illegal_o is low, and rd_o holds bits 4:0 of the word.
- R2: A word presented with valid_i high that fails any of those fixed-bit matches drives illegal_o high and valid_o low on the next clock. vd_o and rd_o keep their previous values.
- R3: Bits 11:10 give a left shift of 0 to 3 that is applied to the offset before the addition. The largest shift, 3, is exercised.
- R4: When bits 23:22 = 2'b10, the vector is split into 32-bit lanes and each lane is base + (offset << shift) modulo 2^32.
- R5: When bits 23:22 = 2'b11, the vector is split into 64-bit lanes and each lane is base + (offset << shift) modulo 2^64.
- R6: When bits 23:22 = 2'b00, the vector uses 64-bit lanes. The low 32 bits of each offset lane are sign-extended to 64 bits, shifted and added to the base. The upper 32 offset bits have no effect.
- R7: When bits 23:22 = 2'b01, the vector uses 64-bit lanes. The low 32 bits of each offset lane are zero-extended, shifted and added to the base. The upper 32 offset bits have no effect.
- R8: Carries never cross a lane boundary, and all lanes of the vector are written.
- R9: While rst_ni is low, valid_o, illegal_o, vd_o and rd_o are all zero.
- R10: A cycle with valid_i low leaves valid_o and illegal_o low on the next clock and keeps vd_o and rd_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are present |
| insn_i | input | 32 | Instruction word |
| base_i | input | VLEN | Base vector |
| offs_i | input | VLEN | Offset vector |
| valid_o | output | 1 | vd_o and rd_o carry a new result |
| illegal_o | output | 1 | Previous word failed decode |
| rd_o | output | 5 | Destination register index |
| vd_o | output | VLEN | Result vector |

## Verification
The cases that are hardest to reach are the ones where the two widening modes must ignore the upper half of each offset lane, and where a carry sits right at a lane boundary. Random operands almost never produce a borrow into bit 32 or a sum that is all ones. The stimulus therefore includes directed vectors: offset lanes with garbage in the upper half and bit 31 set, shifted by 3, and base lanes of all ones with an offset of one in both the 32-bit and 64-bit layouts. Every sum in those cases wraps exactly at the lane edge. Random traffic then mixes modes, shifts, idle cycles and corrupted opcodes. A behavioural model checks it on every clock.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_SX32 = 2'b00,
    MODE_ZX32 = 2'b01,
    MODE_P32  = 2'b10,
    MODE_P64  = 2'b11
  } vag_mode_e;

  typedef struct packed {
    logic      legal;
    vag_mode_e mode;
    logic [1:0] shamt;
    logic [4:0] rd;
  } vag_dec_t;

  localparam logic [7:0] OPC_HI  = 8'h04;
  localparam logic [3:0] OPC_MID = 4'hA;
endpackage

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic [31:0] insn_i,
  output vag_dec_t    dec_o
);
  logic unused_src;
  assign unused_src = ^{insn_i[20:16], insn_i[9:5]};

  always_comb begin
    dec_o.legal = (insn_i[31:24] == OPC_HI) && insn_i[21] && (insn_i[15:12] == OPC_MID);
    dec_o.mode  = vag_mode_e'(insn_i[23:22]);
    dec_o.shamt = insn_i[11:10];
    dec_o.rd    = insn_i[4:0];
  end
endmodule

// File: rtl/vag_lane64.sv
module vag_lane64
  import vag_pkg::*;
(
  input  vag_mode_e   mode_i,
  input  logic [1:0]  shamt_i,
  input  logic [63:0] base_i,
  input  logic [63:0] offs_i,
  output logic [63:0] res_o
);
  logic [31:0] lo32, hi32;
  logic [63:0] offs_ext, wide;

  // packed 32-bit pair: separate adders so no carry crosses bit 32
  assign lo32 = base_i[31:0]  + (offs_i[31:0]  << shamt_i);
  assign hi32 = base_i[63:32] + (offs_i[63:32] << shamt_i);

  always_comb begin
    unique case (mode_i)
      MODE_SX32: offs_ext = {{32{offs_i[31]}}, offs_i[31:0]};
      MODE_ZX32: offs_ext = {32'b0, offs_i[31:0]};
      default:   offs_ext = offs_i;
    endcase
  end

  assign wide  = base_i + (offs_ext << shamt_i);
  assign res_o = (mode_i == MODE_P32) ? {hi32, lo32} : wide;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] base_i,
  input  logic [VLEN-1:0] offs_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [4:0]      rd_o,
  output logic [VLEN-1:0] vd_o
);
  localparam int NUM_CHUNK = VLEN / 64;

  vag_dec_t        dec;
  logic [VLEN-1:0] res;

  vag_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  for (genvar g = 0; g < NUM_CHUNK; g++) begin : g_chunk
    vag_lane64 u_lane (
      .mode_i  (dec.mode),
      .shamt_i (dec.shamt),
      .base_i  (base_i[64*g +: 64]),
      .offs_i  (offs_i[64*g +: 64]),
      .res_o   (res[64*g +: 64])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      vd_o      <= '0;
    end else begin
      valid_o   <= valid_i && dec.legal;
      illegal_o <= valid_i && !dec.legal;
      if (valid_i && dec.legal) begin
        rd_o <= dec.rd;
        vd_o <= res;
      end
    end
  end
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int VLEN = 256
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [10:0]     op_hi_i,
  input logic [5:0]      op_mid_i,
  input logic [4:0]      rd_in_i,
  input logic [63:0]     base0_i,
  input logic [63:0]     offs0_i,
  input logic            valid_o,
  input logic            illegal_o,
  input logic [4:0]      rd_o,
  input logic [VLEN-1:0] vd_o
);
  logic legal_in;
  assign legal_in = valid_i && (op_hi_i[10:3] == 8'h04) && op_hi_i[0] && (op_mid_i[5:2] == 4'hA);

  AST_LEGAL_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_in |=> valid_o && !illegal_o); // R1
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_in |=> rd_o == $past(rd_in_i)); // R1
  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legal_in) |=> illegal_o && !valid_o); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_in |=> $stable(vd_o) && $stable(rd_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !illegal_o); // R10
  AST_P64_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_in && op_hi_i[2:1] == 2'b11) |=>
      vd_o[63:0] == $past(base0_i + (offs0_i << op_mid_i[1:0]))); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o)); // R2
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.VLEN(VLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_hi_i   (insn_i[31:21]),
  .op_mid_i  (insn_i[15:10]),
  .rd_in_i   (insn_i[4:0]),
  .base0_i   (base_i[63:0]),
  .offs0_i   (offs_i[63:0]),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .rd_o      (rd_o),
  .vd_o      (vd_o)
);

// File: tb/vec_addr_gen_tb.sv
module vec_addr_gen_tb;
  localparam int  VLEN       = 256;
  localparam time CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            valid_i;
  logic [31:0]     insn_i;
  logic [VLEN-1:0] base_i, offs_i;
  logic            valid_o, illegal_o;
  logic [4:0]      rd_o;
  logic [VLEN-1:0] vd_o;

  int checks = 0;
  int fails  = 0;

  logic            exp_valid, exp_ill;
  logic [4:0]      exp_rd;
  logic [VLEN-1:0] exp_vd;
  string           tag_flag, tag_vd;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_addr_gen #(.VLEN(VLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .base_i(base_i), .offs_i(offs_i), .valid_o(valid_o), .illegal_o(illegal_o),
    .rd_o(rd_o), .vd_o(vd_o)
  );

  function automatic logic [31:0] mk(input logic [1:0] m, input logic [1:0] s,
                                     input logic [4:0] rm, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {8'h04, m, 1'b1, rm, 4'hA, s, rn, rd};
  endfunction

  function automatic bit is_legal(input logic [31:0] w);
    return w[31:24] == 8'h04 && w[21] == 1'b1 && w[15:12] == 4'hA;
  endfunction

  function automatic logic [VLEN-1:0] rvec();
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN/32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [VLEN-1:0] fill32(input logic [31:0] v);
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN/32; i++) r[32*i +: 32] = v;
    return r;
  endfunction

  function automatic logic [VLEN-1:0] fill64(input logic [63:0] v);
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN/64; i++) r[64*i +: 64] = v;
    return r;
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [31:0] w,
                                            input logic [VLEN-1:0] b,
                                            input logic [VLEN-1:0] o);
    logic [VLEN-1:0] r;
    int sh = w[11:10];
    if (w[23:22] == 2'b10) begin
      for (int i = 0; i < VLEN/32; i++) begin
        longint unsigned s = longint'(b[32*i +: 32]) + (longint'(o[32*i +: 32]) << sh);
        r[32*i +: 32] = s[31:0];
      end
    end else begin
      for (int i = 0; i < VLEN/64; i++) begin
        longint unsigned off;
        case (w[23:22])
          2'b00:   off = longint'(int'(o[64*i +: 32]));
          2'b01:   off = longint'(o[64*i +: 32]);
          default: off = o[64*i +: 64];
        endcase
        r[64*i +: 64] = b[64*i +: 64] + (off << sh);
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag_flag, "valid_o",   VLEN'(valid_o),   VLEN'(exp_valid));
    chk(tag_flag, "illegal_o", VLEN'(illegal_o), VLEN'(exp_ill));
    chk("R1",     "rd_o",      VLEN'(rd_o),      VLEN'(exp_rd));
    chk(tag_vd,   "vd_o",      vd_o,             exp_vd);
  endtask

  // drive just after a falling edge, compare at the next falling edge
  task automatic issue(input logic v, input logic [31:0] w,
                       input logic [VLEN-1:0] b, input logic [VLEN-1:0] o,
                       input string tag);
    valid_i = v; insn_i = w; base_i = b; offs_i = o;
    if (!v) begin
      exp_valid = 0; exp_ill = 0; tag_flag = "R10";
    end else if (is_legal(w)) begin
      exp_valid = 1; exp_ill = 0; tag_flag = "R1";
      exp_vd = model(w, b, o); exp_rd = w[4:0];
    end else begin
      exp_valid = 0; exp_ill = 1; tag_flag = "R2";
    end
    tag_vd = tag;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_ni = 0; valid_i = 0; insn_i = '0; base_i = '0; offs_i = '0;
    exp_valid = 0; exp_ill = 0; exp_rd = '0; exp_vd = '0;
    repeat (3) @(negedge clk);
    tag_flag = "R9"; tag_vd = "R9";
    chk("R9", "rd_o", VLEN'(rd_o), '0);
    compare();
    rst_ni = 1;
    @(negedge clk);

    // R5 basic
    issue(1, mk(2'b11, 2'd0, 5'd1, 5'd2, 5'd3), fill64(64'd100), fill64(64'd23), "R5");
    // R8 wrap at every 32-bit and 64-bit lane edge
    issue(1, mk(2'b10, 2'd0, 5'd4, 5'd5, 5'd6), {VLEN{1'b1}}, fill32(32'd1), "R8");
    issue(1, mk(2'b11, 2'd0, 5'd4, 5'd5, 5'd7), {VLEN{1'b1}}, fill64(64'd1), "R8");
    // R6/R7 with garbage upper halves, bit 31 set, max shift
    issue(1, mk(2'b00, 2'd3, 5'd8, 5'd9, 5'd10), fill64(64'h0000_1000_0000_0000),
          fill64(64'hDEAD_BEEF_8000_0000), "R6");
    issue(1, mk(2'b01, 2'd3, 5'd8, 5'd9, 5'd11), fill64(64'h0000_1000_0000_0000),
          fill64(64'hDEAD_BEEF_8000_0000), "R7");
    issue(1, mk(2'b00, 2'd0, 5'd8, 5'd9, 5'd12), fill64(64'd5),
          fill64(64'h1234_5678_FFFF_FFFF), "R6");
    // R3 maximum shift in packed layouts
    issue(1, mk(2'b10, 2'd3, 5'd1, 5'd1, 5'd13), rvec(), rvec(), "R3");
    issue(1, mk(2'b11, 2'd3, 5'd1, 5'd1, 5'd14), rvec(), rvec(), "R3");
    // R2 corrupted fixed bits; outputs must hold
    issue(1, mk(2'b11, 2'd1, 5'd2, 5'd2, 5'd30) & ~32'h0020_0000, rvec(), rvec(), "R2");
    issue(1, mk(2'b10, 2'd1, 5'd2, 5'd2, 5'd29) ^ 32'h1000_0000, rvec(), rvec(), "R2");
    issue(1, mk(2'b01, 2'd1, 5'd2, 5'd2, 5'd28) ^ 32'h0000_4000, rvec(), rvec(), "R2");
    // R10 idle with a legal word on the bus
    issue(0, mk(2'b11, 2'd2, 5'd2, 5'd2, 5'd27), rvec(), rvec(), "R10");

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 4; k++)
          issue(1, mk(2'(m), 2'(s), 5'($urandom), 5'($urandom), 5'($urandom)),
                rvec(), rvec(), mode_tag(2'(m)));

    for (int k = 0; k < 200; k++) begin
      logic [31:0] w = mk(2'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      int sel = $urandom % 8;
      string t = mode_tag(w[23:22]);
      if (sel == 0) begin w = w ^ (32'h1 << ($urandom % 32)); t = is_legal(w) ? t : "R2"; end
      if (sel == 1) t = "R10";
      issue(sel != 1, w, rvec(), rvec(), t);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule